// File: doc/BRIEF.md
# Credit-Based Queue Shaper

This block gates one egress queue of a switch port with a credit-based shaper. A credit counter grows at a committed rate while the queue waits and shrinks by the bytes sent while it transmits. The queue may start a frame only while that credit is zero or positive. The block is built once per queue; a port with eight queues holds eight copies. Picking which eligible queue sends next, and moving frame data, belong to other blocks.

The configuration is held as three register values. The rate counts in steps of 100 kb/s in a 15-bit field. The credit ceiling counts in 4096-byte steps in a 6-bit field. A single bit turns shaping on. A 2-bit link-speed code tells the block the line rate. Credit is kept internally as bytes multiplied by the line rate in 100 kb/s units. Each byte-time tick then adds exactly the programmed rate value, and each byte sent removes exactly the line-rate value, so the arithmetic stays integer and exact.

With shaping off, the eligible output simply follows the queue's not-empty flag. The output is registered: it reflects the inputs and credit of the previous clock.

Top module: `cbs_queue_shaper`

## Requirements
- R1: During reset and on the first clock after it, `tx_eligible` is 0 and the credit is zero.
- R2: While `cfg_shape_en` is 0, `tx_eligible` equals the value `q_nonempty` had one clock earlier, and the credit is held at zero.
- R3: While shaping, the queue is not empty and no frame is sending, each clock with `byte_tick` high adds the rate value to the scaled credit. A clock without a tick leaves the credit unchanged.
- R4: The scaled credit never exceeds burst × 4096 × L, where L is the line rate in 100 kb/s units.
- R5: While `tx_active` is 1, each clock changes the credit by (tick ? rate : 0) − `tx_bytes` × L.
- R6: While shaping, `tx_eligible` is 1 exactly when `q_nonempty` was 1 and the updated credit is zero or positive.
- R7: With the queue empty, no frame sending and a positive credit, the credit drops to zero on the next clock.
- R8: With the queue empty, no frame sending and a negative credit, the credit rises by the rate on each tick but never above zero.
- R9: While shaping, a rate field of 0 acts as 1, and a burst field of 0 acts as 1.
- R10: `link_speed` codes 0, 1, 2 and 3 select L = 100, 1000, 10000 and 25000, that is 10 Mb/s, 100 Mb/s, 1 Gb/s and 2.5 Gb/s.
- R11: The credit saturates at −2^(CREDIT_W−1) instead of wrapping.
- R12: Turning shaping off clears the credit, so shaping turned back on starts from zero credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shape_en | input | 1 | 1 enables credit shaping for this queue |
| cfg_rate | input | 15 | Committed rate, 100 kb/s units |
| cfg_burst | input | 6 | Credit ceiling, 4096-byte units |
| link_speed | input | 2 | Line-rate code (0=10M, 1=100M, 2=1G, 3=2.5G) |
| q_nonempty | input | 1 | Queue holds at least one frame |
| tx_active | input | 1 | A frame from this queue is being sent |
| tx_bytes | input | 4 | Bytes sent this clock, meaningful while tx_active |
| byte_tick | input | 1 | One pulse per byte time at the line rate |
| tx_eligible | output | 1 | Queue may start a frame (registered) |

## Verification
The assertions assume that `tx_bytes` matters only while `tx_active` is high. They also assume that the ceiling chosen by burst and speed fits in the credit width. Configuration may change on any clock. The properties are stated so that a changed ceiling or rate takes effect on the same edge. The stimulus never leaves these bounds: in the narrower-credit bench instance, bursts at the fastest speed stay small enough that every ceiling is representable. The floor case is reached by long, unbroken sending at the highest line rate with no ticks.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [1:0] {
    SPD_10M  = 2'd0,
    SPD_100M = 2'd1,
    SPD_1G   = 2'd2,
    SPD_2G5  = 2'd3
  } link_speed_e;

  localparam int LINE_UNIT_W = 15;

  // Line rate expressed in 100 kb/s units for each speed code.
  function automatic logic [LINE_UNIT_W-1:0] line_units(link_speed_e s);
    case (s)
      SPD_10M:  return LINE_UNIT_W'(100);
      SPD_100M: return LINE_UNIT_W'(1000);
      SPD_1G:   return LINE_UNIT_W'(10000);
      default:  return LINE_UNIT_W'(25000);
    endcase
  endfunction

endpackage

// File: rtl/cbs_cfg_decode.sv
module cbs_cfg_decode #(
  parameter int RATE_W      = 15,
  parameter int BURST_W     = 6,
  parameter int BURST_SHIFT = 12,
  parameter int LINE_W      = 15,
  parameter int CREDIT_W    = 34
) (
  input  logic [RATE_W-1:0]          cfg_rate,
  input  logic [BURST_W-1:0]         cfg_burst,
  input  cbs_pkg::link_speed_e       speed,
  output logic [RATE_W-1:0]          rate_eff,
  output logic [LINE_W-1:0]          line_u,
  output logic signed [CREDIT_W-1:0] ceil_c
);
  localparam int BYTE_W = BURST_W + BURST_SHIFT;

  logic [BURST_W-1:0]  burst_eff;
  logic [BYTE_W-1:0]   ceil_bytes;
  logic [CREDIT_W-1:0] ceil_prod;

  always_comb begin
    // R9: a zero field is never used as zero
    rate_eff   = (cfg_rate == '0) ? RATE_W'(1) : cfg_rate;
    burst_eff  = (cfg_burst == '0) ? BURST_W'(1) : cfg_burst;
    ceil_bytes = {burst_eff, {BURST_SHIFT{1'b0}}};
    line_u     = LINE_W'(cbs_pkg::line_units(speed));
    ceil_prod  = CREDIT_W'(ceil_bytes) * CREDIT_W'(line_u);
    ceil_c     = $signed(ceil_prod);
  end

endmodule

// File: rtl/cbs_credit_acc.sv
module cbs_credit_acc #(
  parameter int RATE_W   = 15,
  parameter int LINE_W   = 15,
  parameter int TXB_W    = 4,
  parameter int CREDIT_W = 34
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       q_nonempty,
  input  logic                       tx_active,
  input  logic [TXB_W-1:0]           tx_bytes,
  input  logic                       byte_tick,
  input  logic [RATE_W-1:0]          rate_eff,
  input  logic [LINE_W-1:0]          line_u,
  input  logic signed [CREDIT_W-1:0] ceil_c,
  output logic signed [CREDIT_W-1:0] credit_q,
  output logic signed [CREDIT_W-1:0] credit_nxt
);
  localparam int SUM_W = CREDIT_W + 2;
  localparam logic signed [CREDIT_W-1:0] FLOOR = {1'b1, {(CREDIT_W-1){1'b0}}};

  logic signed [SUM_W-1:0] gain, cost, base, raw, ceil_x, floor_x;

  always_comb begin
    gain    = byte_tick ? $signed(SUM_W'(rate_eff)) : '0;
    cost    = tx_active ? $signed(SUM_W'(tx_bytes) * SUM_W'(line_u)) : '0;
    base    = SUM_W'(credit_q);
    ceil_x  = SUM_W'(ceil_c);
    floor_x = SUM_W'(FLOOR);
    raw     = base + gain - cost;
    if (!tx_active && !q_nonempty) begin
      if (credit_q > 0)  raw = '0;
      else if (raw > 0)  raw = '0;
    end
    if (raw > ceil_x)       raw = ceil_x;
    else if (raw < floor_x) raw = floor_x;
    credit_nxt = raw[CREDIT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) credit_q <= '0;
    else            credit_q <= credit_nxt;
  end

  // R4
  ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> credit_q <= $past(ceil_c));

  // R7
  empty_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !q_nonempty && !tx_active && credit_q > 0) |=> credit_q == 0);

  // R12
  disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> credit_q == 0);

  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && q_nonempty && !tx_active && !byte_tick && credit_q <= ceil_c)
    |=> credit_q == $past(credit_q));

endmodule

// File: rtl/cbs_elig.sv
module cbs_elig (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic q_nonempty,
  input  logic credit_neg,
  output logic tx_eligible
);
  always_ff @(posedge clk) begin
    if (rst) tx_eligible <= 1'b0;
    else     tx_eligible <= q_nonempty && (!en || !credit_neg);
  end

  // R2
  follow_q_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> tx_eligible == $past(q_nonempty));

  // R6
  elig_needs_q_chk: assert property (@(posedge clk) disable iff (rst)
    tx_eligible |-> $past(q_nonempty));

endmodule

// File: rtl/cbs_queue_shaper.sv
module cbs_queue_shaper #(
  parameter int RATE_W      = 15,
  parameter int BURST_W     = 6,
  parameter int BURST_SHIFT = 12,
  parameter int TXB_W       = 4,
  parameter int CREDIT_W    = 34
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_shape_en,
  input  logic [RATE_W-1:0]  cfg_rate,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic [1:0]         link_speed,
  input  logic               q_nonempty,
  input  logic               tx_active,
  input  logic [TXB_W-1:0]   tx_bytes,
  input  logic               byte_tick,
  output logic               tx_eligible
);
  localparam int LINE_W = cbs_pkg::LINE_UNIT_W;

  logic [RATE_W-1:0]          rate_eff;
  logic [LINE_W-1:0]          line_u;
  logic signed [CREDIT_W-1:0] ceil_c;
  logic signed [CREDIT_W-1:0] credit_q;
  logic signed [CREDIT_W-1:0] credit_nxt;

  cbs_cfg_decode #(
    .RATE_W(RATE_W), .BURST_W(BURST_W), .BURST_SHIFT(BURST_SHIFT),
    .LINE_W(LINE_W), .CREDIT_W(CREDIT_W)
  ) u_cfg (
    .cfg_rate (cfg_rate),
    .cfg_burst(cfg_burst),
    .speed    (cbs_pkg::link_speed_e'(link_speed)),
    .rate_eff (rate_eff),
    .line_u   (line_u),
    .ceil_c   (ceil_c)
  );

  cbs_credit_acc #(
    .RATE_W(RATE_W), .LINE_W(LINE_W), .TXB_W(TXB_W), .CREDIT_W(CREDIT_W)
  ) u_acc (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_shape_en),
    .q_nonempty(q_nonempty),
    .tx_active (tx_active),
    .tx_bytes  (tx_bytes),
    .byte_tick (byte_tick),
    .rate_eff  (rate_eff),
    .line_u    (line_u),
    .ceil_c    (ceil_c),
    .credit_q  (credit_q),
    .credit_nxt(credit_nxt)
  );

  cbs_elig u_elig (
    .clk        (clk),
    .rst        (rst),
    .en         (cfg_shape_en),
    .q_nonempty (q_nonempty),
    .credit_neg (credit_nxt[CREDIT_W-1]),
    .tx_eligible(tx_eligible)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !tx_eligible && credit_q == 0);

endmodule

// File: tb/tb_cbs_queue_shaper.sv
module tb_cbs_queue_shaper;
  localparam int CW = 30;
  localparam longint FLOOR = -(longint'(1) << (CW - 1));

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [14:0] rate = '0;
  logic [5:0]  burst = '0;
  logic [1:0]  spd = '0;
  logic        q = 1'b0;
  logic        txa = 1'b0;
  logic [3:0]  txb = '0;
  logic        tick = 1'b0;
  logic        tx_eligible;

  int     checks = 0;
  int     fails = 0;
  longint m_cred = 0;
  bit     m_elig = 1'b0;
  bit [31:0] lf = 32'h1234_5678;

  always #10 clk = ~clk;

  cbs_queue_shaper #(.CREDIT_W(CW)) dut (
    .clk(clk), .rst(rst), .cfg_shape_en(en), .cfg_rate(rate),
    .cfg_burst(burst), .link_speed(spd), .q_nonempty(q),
    .tx_active(txa), .tx_bytes(txb), .byte_tick(tick),
    .tx_eligible(tx_eligible)
  );

  function automatic longint lu(logic [1:0] s);
    case (s)
      2'd0: return 100;
      2'd1: return 1000;
      2'd2: return 10000;
      default: return 25000;
    endcase
  endfunction

  task automatic model_step();
    longint l, r, c, g, k, n;
    l = lu(spd);
    r = (rate == 0) ? 1 : longint'(rate);
    c = ((burst == 0) ? 1 : longint'(burst)) * 4096 * l;
    if (rst) begin
      m_cred = 0; m_elig = 1'b0;
    end else if (!en) begin
      m_cred = 0; m_elig = q;
    end else begin
      g = tick ? r : 0;
      k = txa ? longint'(txb) * l : 0;
      n = m_cred + g - k;
      if (!txa && !q) begin
        if (m_cred > 0) n = 0;
        else if (n > 0) n = 0;
      end
      if (n > c) n = c;
      if (n < FLOOR) n = FLOOR;
      m_cred = n;
      m_elig = q && (n >= 0);
    end
  endtask

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s tx_eligible=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tx_eligible, m_elig, req);
  endtask

  task automatic steps(input int n, input string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic lfsr_next();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    steps(3, "R1");
    rst = 1'b0;
    step("R1");
    check(tx_eligible, 1'b0, "R1");

    // R2: shaping off, output tracks queue flag
    for (int i = 0; i < 12; i++) begin
      q = (i % 3) != 0;
      txa = (i % 4) == 1;
      txb = 4'd15;
      step("R2");
    end

    // R3 and R4: accumulate up to ceiling at 10 Mb/s
    en = 1'b1; spd = 2'd0; rate = 15'd32767; burst = 6'd1;
    q = 1'b1; txa = 1'b0; tick = 1'b1;
    steps(20, "R3");
    tick = 1'b0;
    steps(3, "R3");
    txa = 1'b1; txb = 4'd15;
    steps(280, "R4");

    // R5: send slope with ticks during transmission
    rate = 15'd1000; tick = 1'b1; txb = 4'd15;
    steps(6, "R5");
    txb = 4'd5;
    steps(8, "R5");
    txb = 4'd15;
    steps(4, "R5");

    // R6: queue flag gating
    txa = 1'b0; tick = 1'b0;
    for (int i = 0; i < 6; i++) begin
      q = i[0];
      step("R6");
    end

    // R7: empty queue drops positive credit
    q = 1'b1; tick = 1'b1; rate = 15'd32767;
    steps(10, "R7");
    q = 1'b0; tick = 1'b0;
    step("R7");
    q = 1'b1; txa = 1'b1; txb = 4'd1;
    step("R7");
    txa = 1'b0;
    steps(3, "R7");

    // R8: negative credit recovers only up to zero while empty
    q = 1'b0; rate = 15'd30; tick = 1'b1;
    steps(10, "R8");
    q = 1'b1; tick = 1'b0; txa = 1'b1; txb = 4'd1;
    step("R8");
    txa = 1'b0; tick = 1'b1;
    steps(6, "R8");

    // R9: zero fields act as one
    rate = '0; burst = '0; tick = 1'b0; txa = 1'b1; txb = 4'd1;
    step("R9");
    txa = 1'b0; tick = 1'b1;
    steps(110, "R9");

    // R10: every speed code under varied stimulus
    for (int s = 0; s < 4; s++) begin
      spd = 2'(s);
      for (int i = 0; i < 300; i++) begin
        lfsr_next();
        q = lf[0] | lf[1];
        txa = lf[2] & lf[3];
        txb = lf[7:4];
        tick = lf[8];
        if (lf[9] & lf[10] & lf[11]) rate = lf[26:12];
        if (lf[27] & lf[28]) burst = 6'(1 + lf[30:29]);
        step("R10");
      end
    end

    // R11: floor saturation then exact recovery time
    spd = 2'd3; burst = 6'd1; q = 1'b1; txa = 1'b1; txb = 4'd15; tick = 1'b0;
    steps(1800, "R11");
    txa = 1'b0; tick = 1'b1; rate = 15'd32767;
    steps(16400, "R11");

    // R12: disabling clears credit
    txa = 1'b1; tick = 1'b0;
    steps(10, "R12");
    en = 1'b0; txa = 1'b0;
    steps(2, "R12");
    en = 1'b1; q = 1'b1;
    steps(3, "R12");
    check(tx_eligible, 1'b1, "R12");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule